// File: doc/BRIEF.md
# Subtractive GCD Engine

This block finds the greatest common divisor of two unsigned operands by repeated subtraction. It is built as a small controller next to a datapath. The controller reads two status bits from the datapath: one says the two working values differ, the other says the first is below the second. From these bits it drives the mux selects and load enables of the two working registers and of the result register.

A caller presents both operands and raises `start` for one cycle while the engine is idle. The engine captures both operands on that edge. It then removes the smaller working value from the larger one, one subtraction per clock. When the two values match, or when either of them is zero, it writes the answer to `gcd_out` and pulses `done`. `gcd_out` keeps that answer until the next job finishes. Any `start` that arrives while a job is running is ignored.

Top module: `gcd_sub_engine`

## Requirements
- R1: While reset is held and after it is released, `done` is 0 and `gcd_out` is 0 until the first job completes.
- R2: A high `start` in the idle state captures `opnd_a` and `opnd_b` on that clock edge. The input values after that edge have no effect on the job.
- R3: Each busy cycle with two distinct nonzero working values performs exactly one subtraction, the smaller from the larger. The working values therefore never increase and never become zero.
- R4: When both working values are equal and nonzero, `gcd_out` receives that value. `done` rises k+2 clock edges after the `start` edge, where k is the number of subtractions performed.
- R5: If one operand is zero, the result is the other operand. If both are zero, the result is 0. In both cases `done` rises 2 edges after the `start` edge.
- R6: `done` is high for exactly one cycle per completed job.
- R7: `gcd_out` changes only on the cycle in which `done` is high, and otherwise holds its value.
- R8: A `start` that arrives while a job is running is ignored. The running job keeps its result and its latency.
- R9: The operand width is the parameter `W` (default 16), and the same behaviour holds at other widths, such as 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a job; only acted on while idle |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| gcd_out | output | W | Last computed divisor, held between jobs |
| done | output | 1 | One-cycle pulse when `gcd_out` is written |

## Verification
The hardest condition to reach from the ports is a second `start` that lands mid-job. The engine must ignore it, and the effect shows only if the job runs long enough to overlap it. The bench starts a job with operands 100 and 1, which needs 99 subtractions, and then raises `start` with different operands a few cycles later. It then checks that both the result and the completion latency match the first job alone. A pair of 65535 and 1 drives the longest loop at the default width, and zero operands cover the early-exit path.

// File: rtl/gcd_sub_engine.sv
module gcd_sub_engine #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] gcd_out,
  output logic         done
);

  typedef enum logic {S_IDLE, S_RUN} st_t;
  st_t st, st_nx;

  logic [W-1:0] ra, rb;
  logic         a_sel, b_sel, a_ld, b_ld, r_ld;
  logic         neq, lt, a_zero, b_zero, fin;

  // datapath status
  assign neq    = ra != rb;
  assign lt     = ra < rb;
  assign a_zero = ra == '0;
  assign b_zero = rb == '0;
  assign fin    = a_zero | b_zero | !neq;

  // controller
  always_comb begin
    st_nx = st;
    a_sel = 1'b0;
    b_sel = 1'b0;
    a_ld  = 1'b0;
    b_ld  = 1'b0;
    r_ld  = 1'b0;
    case (st)
      S_IDLE: if (start) begin
        a_ld  = 1'b1;
        b_ld  = 1'b1;
        st_nx = S_RUN;
      end
      S_RUN: begin
        if (fin) begin
          r_ld  = 1'b1;
          st_nx = S_IDLE;
        end else if (lt) begin
          b_sel = 1'b1;
          b_ld  = 1'b1;
        end else begin
          a_sel = 1'b1;
          a_ld  = 1'b1;
        end
      end
      default: st_nx = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ra      <= '0;
      rb      <= '0;
      gcd_out <= '0;
      done    <= 1'b0;
    end else begin
      st   <= st_nx;
      done <= r_ld;
      if (a_ld) ra <= a_sel ? ra - rb : opnd_a;
      if (b_ld) rb <= b_sel ? rb - ra : opnd_b;
      if (r_ld) gcd_out <= a_zero ? rb : ra;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                             // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(gcd_out));                                 // R7
  AST_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !fin) |=> (ra <= $past(ra) && rb <= $past(rb))); // R3
  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !a_zero && !b_zero) |=> (!a_zero && !b_zero)); // R3
  AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !fin) |=> st == S_RUN);                      // R8

endmodule

// File: tb/gcd_sub_engine_tb.sv
module gcd_sub_engine_tb;

  localparam int W  = 16;
  localparam int NV = 10;
  localparam logic [W-1:0] TA [NV] = '{16'd12, 16'd8,  16'd7, 16'd0, 16'd9,
                                       16'd0,  16'd270, 16'd65535, 16'd17, 16'd48};
  localparam logic [W-1:0] TB [NV] = '{16'd8,  16'd12, 16'd7, 16'd9, 16'd0,
                                       16'd0,  16'd192, 16'd1, 16'd5, 16'd180};
  localparam logic [W-1:0] TE [NV] = '{16'd4,  16'd4,  16'd7, 16'd9, 16'd9,
                                       16'd0,  16'd6,  16'd1, 16'd1, 16'd12};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [W-1:0] opnd_a = '0, opnd_b = '0, gcd_out;
  logic done;
  logic start8 = 1'b0;
  logic [7:0] a8 = '0, b8 = '0, out8;
  logic done8;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  gcd_sub_engine #(.W(W)) u_dut (.clk(clk), .rst_n(rst_n), .start(start),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .gcd_out(gcd_out), .done(done));
  gcd_sub_engine #(.W(8)) u_dut_w8 (.clk(clk), .rst_n(rst_n), .start(start8),
    .opnd_a(a8), .opnd_b(b8), .gcd_out(out8), .done(done8));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int subs_needed(input longint a, input longint b);
    int n = 0;
    if (a == 0 || b == 0) return 0;
    while (a != b) begin
      if (a < b) b = b - a; else a = a - b;
      n++;
    end
    return n;
  endfunction

  function automatic longint ref_gcd(input longint a, input longint b);
    longint t;
    while (b != 0) begin t = a % b; a = b; b = t; end
    return a;
  endfunction

  // launches a job, optionally injects a second start mid-run, returns edges to done
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input bit intrude,
                     output int edges);
    @(negedge clk);
    opnd_a = a; opnd_b = b; start = 1'b1;
    @(posedge clk);
    edges = 1;
    @(negedge clk);
    start = 1'b0; opnd_a = ~a; opnd_b = ~b;
    while (!done && edges < 70000) begin
      if (intrude && edges == 3) begin
        opnd_a = 16'd6; opnd_b = 16'd4; start = 1'b1;
      end
      @(posedge clk);
      edges++;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  initial begin
    int edges;
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    chk(gcd_out == '0, "R1 result in reset", gcd_out, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done == 1'b0 && gcd_out == '0, "R1 after reset", gcd_out, 0);

    for (int i = 0; i < NV; i++) begin
      run(TA[i], TB[i], 1'b0, edges);
      chk(gcd_out == TE[i], "R4/R5 table result (R2 inputs changed)", gcd_out, TE[i]);
      chk(edges == subs_needed(TA[i], TB[i]) + 2, "R3/R4/R5 latency",
          edges, subs_needed(TA[i], TB[i]) + 2);
      @(negedge clk);
      chk(done == 1'b0, "R6 done one cycle", done, 0);
    end

    for (int i = 0; i < 6; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom_range(1, 1023));
      b = W'($urandom_range(1, 1023));
      run(a, b, 1'b0, edges);
      chk(gcd_out == W'(ref_gcd(a, b)), "R4 random result", gcd_out, ref_gcd(a, b));
      chk(edges == subs_needed(a, b) + 2, "R3 random latency", edges, subs_needed(a, b) + 2);
    end

    held = gcd_out;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      opnd_a = W'(i * 7); opnd_b = W'(i + 3);
    end
    chk(gcd_out == held && done == 1'b0, "R7 result held", gcd_out, held);

    run(16'd100, 16'd1, 1'b1, edges);
    chk(gcd_out == 16'd1, "R8 result with mid-run start", gcd_out, 1);
    chk(edges == 101, "R8 latency with mid-run start", edges, 101);
    @(negedge clk);
    chk(done == 1'b0 && gcd_out == 16'd1, "R8 no second job", gcd_out, 1);

    @(negedge clk);
    a8 = 8'd200; b8 = 8'd150; start8 = 1'b1;
    @(negedge clk);
    start8 = 1'b0;
    edges = 1;
    while (!done8 && edges < 1000) begin @(negedge clk); edges++; end
    chk(out8 == 8'd50, "R9 width 8 result", out8, 50);
    chk(edges == subs_needed(200, 150) + 2, "R9 width 8 latency", edges, subs_needed(200, 150) + 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule